// File: doc/BRIEF.md
# Oscillator Bias-Resistor Fault Supervisor

This block holds the control settings of a tunable oscillator whose bias current can come from an on-chip resistor or from a resistor fitted to an external pin. Software programs a bias-mode bit, a 3-bit band select and a 10-bit signed trim through a small register port. The block drives these settings to the analog side, where the trim is passed through unchanged.

Two asynchronous fault indications come back from the analog side: the external pin is open, or the external pin is shorted to ground. An open pin makes the block fall back to the on-chip resistor without touching the band or the trim, and it raises a sticky flag that drives the interrupt output. A shorted pin makes the block issue a one-cycle reset request and latch a fault flag and a cause bit. These two bits live in a domain that only the power-on reset clears, so they survive the reset that the block requests. A fault is acted on only while external mode is active or is being entered by the current write.

Register map (wr_addr / rd_addr): 0 = mode (bit 0: 1 external, 0 internal), 1 = band (bits 2:0), 2 = trim (bits 9:0), 3 = status on read (bit 0 open flag, bit 1 short flag, bit 2 short cause, bit 3 entry-refused flag) and clear on write (a 1 in bit 0, 1 or 3 clears the matching flag; bit 1 clears both short flag and short cause). Unused read bits are 0.

Top module: `osc_bias_supervisor`

## Requirements
- R1: After reset the mode is internal (0), the band is 1, the trim is 0, all four status bits are 0, and irq and rst_req are low.
- R2: A write of 1 to the mode register while internal is accepted only if the band holds 1; otherwise the mode stays 0 and status bit 3 is set until a status write with bit 3 set clears it.
- R3: Band writes of 0 to 5 are stored; writes of 6 or 7 leave the band unchanged.
- R4: Trim writes store bits 9:0 of the written data, which appear on osc_tune and read back in bits 9:0 of address 2.
- R5: An open-pin fault in external mode returns the mode to 0, keeps band and trim, sets status bit 0 and drives irq high.
- R6: An open-pin fault present while external mode is being entered leaves the mode at 0 and sets status bit 0.
- R7: With the mode at 0 and no entry write, either fault input has no effect on the status bits or on rst_req.
- R8: A status write with bit 0 set clears the open flag only while the mode is 0; in external mode it is ignored.
- R9: A short-pin fault in external mode, or during an accepted entry write, drives rst_req high for exactly one cycle and sets status bits 1 and 2 in that cycle; short_cause follows status bit 2.
- R10: The cycle after rst_req, mode, band, trim, open flag and entry flag return to their defaults; status bits 1 and 2 survive rst_n and are cleared only by por_n or by one status write with bit 1 set.
- R11: A fault input passes through a two-stage synchronizer, so it takes effect on the third rising clock edge after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset, also clears short flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| fault_open_a | input | 1 | Asynchronous open-pin fault from the analog side |
| fault_short_a | input | 1 | Asynchronous shorted-pin fault from the analog side |
| osc_ext_sel | output | 1 | Bias source select to the oscillator (1 external) |
| osc_range | output | 3 | Band select to the oscillator |
| osc_tune | output | 10 | Signed trim to the oscillator |
| irq | output | 1 | Interrupt, high while the open flag is set |
| rst_req | output | 1 | One-cycle reset request on a short fault |
| short_cause | output | 1 | Latched short cause for the reset controller |

## Verification
A wrong mode bit shows on osc_ext_sel and in the mode read one cycle after the offending write or on the third edge after a fault rises, so the bench samples at exactly those points. A flag that sets or clears wrongly shows at once on irq, short_cause or the status read, and a missing or doubled reset request shows as a wrong pulse count on rst_req. A reset that wipes too much or too little shows as band, trim or short bits that differ from their defaults the cycle after the request, and after a system reset.

// File: rtl/osc_sup_pkg.sv
// Package: shared register selectors and status bit positions for the
// oscillator bias-resistor fault supervisor.
// Assumes: 2-bit register address space.
package osc_sup_pkg;

    typedef enum logic [1:0] {
        REG_MODE  = 2'd0,
        REG_RANGE = 2'd1,
        REG_TUNE  = 2'd2,
        REG_STAT  = 2'd3
    } reg_sel_e;

    localparam int STAT_OPEN  = 0;
    localparam int STAT_SHORT = 1;
    localparam int STAT_CAUSE = 2;
    localparam int STAT_ERR   = 3;

    typedef struct packed {
        logic short_pin;
        logic open_pin;
    } fault_t;

endpackage

// File: rtl/osc_fault_sync.sv
// Module: multi-bit, multi-stage synchronizer for level fault inputs.
// Each bit gets its own shift chain; the output is the last stage.
// Assumes: STAGES >= 2, inputs are slow levels (no pulse capture needed).
module osc_fault_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    initial begin
        if (STAGES < 2) $error("osc_fault_sync needs at least two stages");
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the raw level through the stage chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_async[b]};
        end

        assign q_sync[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/osc_sup_regs.sv
// Module: main-domain control registers (mode, band, trim) plus the open
// flag and the entry-refused flag.
// Assumes: soft_rst is the block's own one-cycle reset request and clears
// everything here like rst_n; FIELD_W covers the band, trim and status bits.
module osc_sup_regs
    import osc_sup_pkg::*;
#(
    parameter int RANGE_W     = 3,
    parameter int TUNE_W      = 10,
    parameter int RANGE_COUNT = 6,
    parameter int RANGE_DFLT  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               wr_en,
    input  reg_sel_e           wr_sel,
    input  logic [TUNE_W-1:0]  wr_field,
    input  logic               open_s,
    output logic               mode_q,
    output logic [RANGE_W-1:0] range_q,
    output logic [TUNE_W-1:0]  tune_q,
    output logic               open_flag_q,
    output logic               entry_err_q,
    output logic               ext_qual
);

    localparam logic [RANGE_W:0]   RANGE_LIM = (RANGE_W+1)'(RANGE_COUNT);
    localparam logic [RANGE_W-1:0] RANGE_DEF = RANGE_W'(RANGE_DFLT);

    logic wr_mode, wr_range, wr_tune, wr_stat;
    logic enter_req, enter_ok, enter_bad, open_hit, range_ok, clr_ok;
    logic mode_d;
    logic any_rst;

    // Decode write strobes and the entry/fault qualifiers.
    always_comb begin
        wr_mode   = wr_en && (wr_sel == REG_MODE);
        wr_range  = wr_en && (wr_sel == REG_RANGE);
        wr_tune   = wr_en && (wr_sel == REG_TUNE);
        wr_stat   = wr_en && (wr_sel == REG_STAT);
        enter_req = wr_mode && wr_field[0] && !mode_q;
        enter_ok  = enter_req && (range_q == RANGE_DEF);
        enter_bad = enter_req && (range_q != RANGE_DEF);
        ext_qual  = mode_q || enter_ok;
        open_hit  = open_s && ext_qual;
        range_ok  = ({1'b0, wr_field[RANGE_W-1:0]} < RANGE_LIM);
        clr_ok    = wr_stat && wr_field[STAT_OPEN] && !mode_q;
        any_rst   = !rst_n || soft_rst;
    end

    // Next mode: software request, gated entry, open fault forces internal.
    always_comb begin
        mode_d = mode_q;
        if (wr_mode) mode_d = wr_field[0] ? (mode_q || enter_ok) : 1'b0;
        if (open_hit) mode_d = 1'b0;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (any_rst) mode_q <= 1'b0;
        else         mode_q <= mode_d;
    end

    // Band register; encodings at or above RANGE_COUNT are dropped.
    always_ff @(posedge clk) begin
        if (any_rst)                   range_q <= RANGE_DEF;
        else if (wr_range && range_ok) range_q <= wr_field[RANGE_W-1:0];
    end

    // Trim register.
    always_ff @(posedge clk) begin
        if (any_rst)      tune_q <= '0;
        else if (wr_tune) tune_q <= wr_field;
    end

    // Sticky open flag; set wins over a clear, clear only in internal mode.
    always_ff @(posedge clk) begin
        if (any_rst)       open_flag_q <= 1'b0;
        else if (open_hit) open_flag_q <= 1'b1;
        else if (clr_ok)   open_flag_q <= 1'b0;
    end

    // Sticky entry-refused flag.
    always_ff @(posedge clk) begin
        if (any_rst)                                entry_err_q <= 1'b0;
        else if (enter_bad)                         entry_err_q <= 1'b1;
        else if (wr_stat && wr_field[STAT_ERR])     entry_err_q <= 1'b0;
    end

    p_entry_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && (range_q != RANGE_DEF)) |=> !mode_q)
        else $error("external mode entered away from the default band");

    p_range_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, range_q} < RANGE_LIM))
        else $error("band register holds an invalid encoding");

    p_open_forces_int_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (open_s && mode_q) |=> !mode_q)
        else $error("open fault did not return to internal mode");

    p_open_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (open_s && mode_q && !soft_rst) |=> open_flag_q)
        else $error("open fault did not set the open flag");

    p_clear_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (open_flag_q && mode_q && !soft_rst) |=> open_flag_q)
        else $error("open flag cleared while in external mode");

endmodule

// File: rtl/osc_sup_short.sv
// Module: short-fault escalation. Issues a one-cycle reset request and keeps
// the short flag and short cause in the power-on domain.
// Assumes: ext_qual is high while external mode is active or being entered.
module osc_sup_short (
    input  logic clk,
    input  logic rst_n,
    input  logic por_n,
    input  logic short_s,
    input  logic ext_qual,
    input  logic clr_short,
    output logic rst_req,
    output logic short_flag,
    output logic short_cause
);

    logic short_hit;

    // A qualified short, suppressed during the pulse itself.
    always_comb short_hit = short_s && ext_qual && !rst_req;

    // Reset request pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= short_hit;
    end

    // Power-on-domain flag and cause; set wins, one clear drops both.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            short_flag  <= 1'b0;
            short_cause <= 1'b0;
        end else if (short_hit) begin
            short_flag  <= 1'b1;
            short_cause <= 1'b1;
        end else if (clr_short) begin
            short_flag  <= 1'b0;
            short_cause <= 1'b0;
        end
    end

    p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req)
        else $error("reset request longer than one cycle");

    p_req_sets_cause_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |-> (short_flag && short_cause))
        else $error("reset request without latched short bits");

    p_req_needs_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(ext_qual))
        else $error("reset request while not in external mode");

    p_cause_survives_r10: assert property (@(posedge clk) disable iff (!por_n)
        (short_cause && !clr_short) |=> short_cause)
        else $error("short cause lost without a clear");

endmodule

// File: rtl/osc_bias_supervisor.sv
// Module: top of the oscillator bias-resistor fault supervisor. Synchronizes
// the two fault inputs, holds the control registers, escalates shorts and
// provides a combinational register read port.
// Assumes: DATA_W >= TUNE_W >= 4 and TUNE_W >= RANGE_W.
module osc_bias_supervisor
    import osc_sup_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int RANGE_W     = 3,
    parameter int TUNE_W      = 10,
    parameter int RANGE_COUNT = 6,
    parameter int RANGE_DFLT  = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [1:0]         rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               fault_open_a,
    input  logic               fault_short_a,
    output logic               osc_ext_sel,
    output logic [RANGE_W-1:0] osc_range,
    output logic [TUNE_W-1:0]  osc_tune,
    output logic               irq,
    output logic               rst_req,
    output logic               short_cause
);

    localparam int FAULT_W = $bits(fault_t);

    fault_t             fault_raw, fault_s;
    reg_sel_e           wr_sel;
    logic [TUNE_W-1:0]  wr_field;
    logic               mode_q, open_flag_q, entry_err_q, ext_qual;
    logic               short_flag, clr_short;
    logic [RANGE_W-1:0] range_q;
    logic [TUNE_W-1:0]  tune_q;
    logic               unused_wr_bits;

    // Port-level decode shared by the submodules.
    always_comb begin
        fault_raw.open_pin  = fault_open_a;
        fault_raw.short_pin = fault_short_a;
        wr_sel         = reg_sel_e'(wr_addr);
        wr_field       = wr_data[TUNE_W-1:0];
        clr_short      = wr_en && (wr_sel == REG_STAT) && wr_data[STAT_SHORT];
        unused_wr_bits = ^wr_data[DATA_W-1:TUNE_W];
    end

    osc_fault_sync #(
        .WIDTH  (FAULT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (fault_raw),
        .q_sync  (fault_s)
    );

    osc_sup_regs #(
        .RANGE_W     (RANGE_W),
        .TUNE_W      (TUNE_W),
        .RANGE_COUNT (RANGE_COUNT),
        .RANGE_DFLT  (RANGE_DFLT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (rst_req),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_field    (wr_field),
        .open_s      (fault_s.open_pin),
        .mode_q      (mode_q),
        .range_q     (range_q),
        .tune_q      (tune_q),
        .open_flag_q (open_flag_q),
        .entry_err_q (entry_err_q),
        .ext_qual    (ext_qual)
    );

    osc_sup_short u_short (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_n       (por_n),
        .short_s     (fault_s.short_pin),
        .ext_qual    (ext_qual),
        .clr_short   (clr_short),
        .rst_req     (rst_req),
        .short_flag  (short_flag),
        .short_cause (short_cause)
    );

    // Combinational register read mux.
    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_addr))
            REG_MODE:  rd_data[0]           = mode_q;
            REG_RANGE: rd_data[RANGE_W-1:0] = range_q;
            REG_TUNE:  rd_data[TUNE_W-1:0]  = tune_q;
            REG_STAT: begin
                rd_data[STAT_OPEN]  = open_flag_q;
                rd_data[STAT_SHORT] = short_flag;
                rd_data[STAT_CAUSE] = short_cause;
                rd_data[STAT_ERR]   = entry_err_q;
            end
            default: rd_data = '0;
        endcase
    end

    assign osc_ext_sel = mode_q;
    assign osc_range   = range_q;
    assign osc_tune    = tune_q;
    assign irq         = open_flag_q;

    p_irq_follows_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_s.open_pin && mode_q && !rst_req) |=> irq)
        else $error("irq not raised by open fault");

endmodule

// File: tb/tb_osc_bias_supervisor.sv
module tb_osc_bias_supervisor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        fault_open_a = 1'b0;
    logic        fault_short_a = 1'b0;
    logic        osc_ext_sel;
    logic [2:0]  osc_range;
    logic [9:0]  osc_tune;
    logic        irq, rst_req, short_cause;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int cycles = 0;
    bit done = 1'b0;

    localparam logic [1:0] A_MODE = 2'd0, A_RANGE = 2'd1, A_TUNE = 2'd2, A_STAT = 2'd3;

    osc_bias_supervisor dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .fault_open_a(fault_open_a), .fault_short_a(fault_short_a),
        .osc_ext_sel(osc_ext_sel), .osc_range(osc_range), .osc_tune(osc_tune),
        .irq(irq), .rst_req(rst_req), .short_cause(short_cause)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst_req) pulses <= pulses + 1;
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [1:0]  wa;
        logic [15:0] wd;
        logic [1:0]  ra;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 16'h0003, 2'd1, 16'h0003, 4'd3},  // R3 legal band
        '{2'd1, 16'h0006, 2'd1, 16'h0003, 4'd3},  // R3 code 6 dropped
        '{2'd1, 16'h0007, 2'd1, 16'h0003, 4'd3},  // R3 code 7 dropped
        '{2'd1, 16'h0005, 2'd1, 16'h0005, 4'd3},  // R3 top legal band
        '{2'd1, 16'h0000, 2'd1, 16'h0000, 4'd3},  // R3 band 0
        '{2'd1, 16'h0001, 2'd1, 16'h0001, 4'd3},  // R3 back to default
        '{2'd2, 16'h03FF, 2'd2, 16'h03FF, 4'd4},  // R4 trim -1
        '{2'd2, 16'hFE00, 2'd2, 16'h0200, 4'd4},  // R4 most negative, upper bits dropped
        '{2'd2, 16'h0001, 2'd2, 16'h0001, 4'd4},  // R4 trim +1
        '{2'd0, 16'h0001, 2'd0, 16'h0001, 4'd2},  // R2 entry at band 1
        '{2'd0, 16'h0000, 2'd0, 16'h0000, 4'd2},  // R2 leave external
        '{2'd1, 16'h0002, 2'd1, 16'h0002, 4'd3},  // R3 band 2
        '{2'd0, 16'h0001, 2'd0, 16'h0000, 4'd2},  // R2 entry refused
        '{2'd0, 16'h0000, 2'd3, 16'h0008, 4'd2},  // R2 refused flag set
        '{2'd3, 16'h0008, 2'd3, 16'h0000, 4'd2},  // R2 refused flag cleared
        '{2'd1, 16'h0001, 2'd1, 16'h0001, 4'd3}   // R3 band 1 again
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        int p0;
        cyc(3);
        rst_n = 1'b1; por_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(A_MODE, v);  check("R1 mode", v, 16'h0000);
        rd(A_RANGE, v); check("R1 band", v, 16'h0001);
        rd(A_TUNE, v);  check("R1 trim", v, 16'h0000);
        rd(A_STAT, v);  check("R1 status", v, 16'h0000);
        check("R1 outputs", {12'b0, irq, rst_req, short_cause, osc_ext_sel}, 16'h0000);

        // Table of register writes and read-backs
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd(VECS[i].ra, v);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
        end

        // R4 trim drives the oscillator port
        wr(A_TUNE, 16'h0155);
        check("R4 osc_tune", {6'b0, osc_tune}, 16'h0155);

        // R11 / R5 open fault in external mode
        wr(A_MODE, 16'h0001);
        wr(A_RANGE, 16'h0004);
        fault_open_a = 1'b1;
        cyc(2);
        rd(A_MODE, v); check("R11 not yet acted", v, 16'h0001);
        cyc(1);
        rd(A_MODE, v); check("R5 mode internal", v, 16'h0000);
        rd(A_RANGE, v); check("R5 band kept", v, 16'h0004);
        rd(A_TUNE, v);  check("R5 trim kept", v, 16'h0155);
        rd(A_STAT, v);  check("R5 open flag", v, 16'h0001);
        check("R5 irq and sel", {14'b0, irq, osc_ext_sel}, 16'h0002);
        fault_open_a = 1'b0;
        cyc(3);

        // R8 clear ignored in external mode, honoured in internal mode
        wr(A_RANGE, 16'h0001);
        wr(A_MODE, 16'h0001);
        wr(A_STAT, 16'h0001);
        rd(A_STAT, v); check("R8 clear ignored in external", v, 16'h0001);
        wr(A_MODE, 16'h0000);
        wr(A_STAT, 16'h0001);
        rd(A_STAT, v); check("R8 clear in internal", v, 16'h0000);
        check("R8 irq low", {15'b0, irq}, 16'h0000);

        // R7 open fault ignored while internal; R6 open fault at entry
        fault_open_a = 1'b1;
        cyc(4);
        rd(A_STAT, v); check("R7 open ignored internal", v, 16'h0000);
        wr(A_MODE, 16'h0001);
        rd(A_MODE, v); check("R6 entry falls back", v, 16'h0000);
        rd(A_STAT, v); check("R6 open flag", v, 16'h0001);
        fault_open_a = 1'b0;
        cyc(3);
        wr(A_STAT, 16'h0001);

        // R7 short ignored while internal
        p0 = pulses;
        fault_short_a = 1'b1;
        cyc(5);
        rd(A_STAT, v); check("R7 short ignored status", v, 16'h0000);
        check("R7 no reset pulse", 16'(pulses - p0), 16'h0000);
        fault_short_a = 1'b0;
        cyc(3);

        // R9 / R10 short fault in external mode
        wr(A_MODE, 16'h0001);
        wr(A_TUNE, 16'h02AA);
        wr(A_RANGE, 16'h0003);
        p0 = pulses;
        fault_short_a = 1'b1;
        cyc(2);
        check("R11 short not yet acted", {15'b0, rst_req}, 16'h0000);
        cyc(1);
        check("R9 rst_req high", {15'b0, rst_req}, 16'h0001);
        rd(A_STAT, v); check("R9 short bits", v, 16'h0006);
        check("R9 short_cause", {15'b0, short_cause}, 16'h0001);
        cyc(1);
        check("R9 rst_req one cycle", {15'b0, rst_req}, 16'h0000);
        rd(A_MODE, v);  check("R10 mode default", v, 16'h0000);
        rd(A_RANGE, v); check("R10 band default", v, 16'h0001);
        rd(A_TUNE, v);  check("R10 trim default", v, 16'h0000);
        rd(A_STAT, v);  check("R10 short bits kept", v, 16'h0006);
        cyc(4);
        check("R9 single pulse", 16'(pulses - p0), 16'h0001);
        fault_short_a = 1'b0;
        cyc(3);

        // R10 survives system reset, one clear drops both
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
        rd(A_STAT, v); check("R10 kept over rst_n", v, 16'h0006);
        wr(A_STAT, 16'h0002);
        rd(A_STAT, v); check("R10 single clear", v, 16'h0000);
        check("R10 cause port cleared", {15'b0, short_cause}, 16'h0000);

        // R9 short during entry, then R10 power-on reset clears
        fault_short_a = 1'b1;
        cyc(3);
        wr(A_MODE, 16'h0001);
        check("R9 rst_req on entry", {15'b0, rst_req}, 16'h0001);
        fault_short_a = 1'b0;
        cyc(1);
        rd(A_STAT, v); check("R9 entry short bits", v, 16'h0006);
        rst_n = 1'b0; por_n = 1'b0; cyc(2); rst_n = 1'b1; por_n = 1'b1; cyc(1);
        rd(A_STAT, v); check("R10 por clears", v, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule